// File: doc/BRIEF.md
# String Operation Engine

A sequencer that runs repeated string instructions against a byte-addressable memory port. A host loads three working registers and an operation code, then pulses `start`. The registers are a first pointer (P), a second pointer or compare value (Q) and an element count (N). The engine then issues one memory access at a time until the operation's stop rule fires. It keeps zero and carry flags across operations and presents the final register values when it signals completion.

There are seven operations in four families. Compare walks two byte strings. Copy moves bytes forward, backward, or forward until a zero byte. Fill stores a value repeatedly. Search scans for an element that matches, or stops matching, a value at byte, halfword or word size. Instruction decode and caching belong to the surrounding pipeline.

The memory request channel is valid/ready. A request raised by the engine keeps its address, size, write flag and data unchanged until the cycle in which `mem_req_ready` is high; the transfer happens in that cycle. Only one read is ever outstanding. Its data returns on a later cycle with `mem_rsp_valid` high, and the engine always accepts it. Writes get no response.

Top module: `strop_engine`

## Requirements
- R1: A compare (op 0) or a search (op 5, 6) started with N = 0 makes no memory access. It completes with P, Q, N and both flags unchanged.
- R2: Compare (op 0) reads byte a at P, then byte b at Q. It adds 1 to P and Q, subtracts 1 from N, and stops when a != b, when a = 0, or when N reaches 0.
- R3: After a compare, flag_z is 1 when a - b (8 bits) is zero, and flag_c is 1 when a >= b (unsigned), using the last pair of bytes read.
- R4: Copy reads a byte at Q and writes it at P, then subtracts 1 from N. Forward copy (op 1) adds 1 to both pointers and backward copy (op 2) subtracts 1. It runs until N is 0; with N = 0 at start it makes no access. Copy and fill leave the flags unchanged.
- R5: Copy-until-zero (op 3) steps like forward copy and also stops right after it writes a zero byte.
- R6: Fill (op 4) writes the low 1, 2 or 4 bytes of Q at P, little-endian. It adds the element size to P and subtracts 1 from N per store, until N is 0.
- R7: Search-until (op 5) reads an element at P, adds the size to P and subtracts 1 from N, and stops when the element equals Q or N reaches 0. Then flag_z = (element - Q == 0) and flag_c = (element <= Q).
- R8: Search-while (op 6) steps the same way and stops when the element differs from Q or N reaches 0. Then flag_z = (remaining N == 0) and flag_c = (element <= Q).
- R9: For fill and search, size code 0, 1 or 2 selects 1, 2 or 4 bytes. A read element is zero-extended from that many low bytes of `mem_rsp_rdata`. Compare and copy always move single bytes and ignore the size code.
- R10: Op code 7, or size code 3 with op 4, 5 or 6, completes with `err` high during the done cycle. It makes no memory access and leaves registers and flags unchanged.
- R11: A request is held stable while `mem_req_ready` is low. At most one read is outstanding, and no request is raised while the engine is not busy.
- R12: After reset the engine is idle with flags clear. `start` is sampled only when idle. `busy` and `done` are never high together, and `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_in | input | 3 | Operation code 0..7 |
| size_in | input | 2 | Element size code |
| p_in | input | 32 | Initial first pointer |
| q_in | input | 32 | Initial second pointer / compare value / fill value |
| n_in | input | 32 | Initial count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal op or size, valid with done |
| p_out | output | 32 | Current first pointer |
| q_out | output | 32 | Current second register |
| n_out | output | 32 | Current count |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_size | output | 2 | Access size code |
| mem_req_wdata | output | 32 | Write data, low bytes used |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data, little-endian from the address |

## Verification
The bench targets the stop rules:
- A compare that hits a zero byte in equal strings must stop there. An engine that ignored the zero would run on until N is exhausted and finish with a smaller N.
- Copy-until-zero must stop after writing the zero. Stopping one step early or late shows up as a wrong final P and N and as extra or missing bytes in memory.

Zero counts and illegal codes must make no access at all and must keep the previous flags. An engine that flagged from stale data, or touched memory, shows up as changed flags or a nonzero access count. Read data carries nonzero bytes above the element. This exposes a search that fails to zero-extend: its match never fires and its carry comes out wrong. Under a stalling ready, request bytes that drifted before acceptance would land in the wrong place. A start strobed mid-operation would corrupt the result if it were not ignored.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int SZ_W   = 2;

  typedef enum logic [2:0] {
    OP_CMPU  = 3'd0,
    OP_MOVF  = 3'd1,
    OP_MOVB  = 3'd2,
    OP_MOVU  = 3'd3,
    OP_FILL  = 3'd4,
    OP_UNTIL = 3'd5,
    OP_WHILE = 3'd6,
    OP_RSVD  = 3'd7
  } strop_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } strop_state_e;

  function automatic logic [REG_W-1:0] size_bytes(input logic [SZ_W-1:0] sz);
    return REG_W'(1) << sz;
  endfunction

  function automatic logic [REG_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    return REG_W'(32'h0000_00FF);
      2'd1:    return REG_W'(32'h0000_FFFF);
      default: return {REG_W{1'b1}};
    endcase
  endfunction

  function automatic logic op_sized(input strop_op_e op);
    return (op == OP_FILL) || (op == OP_UNTIL) || (op == OP_WHILE);
  endfunction
endpackage

// File: rtl/strop_req_gen.sv
module strop_req_gen
  import strop_pkg::*;
(
  input  strop_op_e         op,
  input  logic              phase,
  input  logic [SZ_W-1:0]   size,
  input  logic [REG_W-1:0]  p_reg,
  input  logic [REG_W-1:0]  q_reg,
  input  logic [BYTE_W-1:0] hold,
  output logic              req_write,
  output logic [REG_W-1:0]  req_addr,
  output logic [SZ_W-1:0]   req_size,
  output logic [REG_W-1:0]  req_wdata
);
  always_comb begin
    req_write = 1'b0;
    req_addr  = p_reg;
    req_size  = '0;
    req_wdata = '0;
    case (op)
      OP_CMPU: req_addr = phase ? q_reg : p_reg;
      OP_MOVF, OP_MOVB, OP_MOVU: begin
        if (phase) begin
          req_write = 1'b1;
          req_addr  = p_reg;
          req_wdata = REG_W'(hold);
        end else begin
          req_addr  = q_reg;
        end
      end
      OP_FILL: begin
        req_write = 1'b1;
        req_size  = size;
        req_wdata = q_reg & size_mask(size);
      end
      OP_UNTIL, OP_WHILE: req_size = size;
      default: req_addr = p_reg;
    endcase
  end
endmodule

// File: rtl/strop_step_eval.sv
module strop_step_eval
  import strop_pkg::*;
(
  input  strop_op_e         op,
  input  logic              phase,
  input  logic [SZ_W-1:0]   size,
  input  logic [REG_W-1:0]  p_reg,
  input  logic [REG_W-1:0]  q_reg,
  input  logic [REG_W-1:0]  n_reg,
  input  logic [BYTE_W-1:0] hold,
  input  logic [REG_W-1:0]  rdata,
  output logic              adv_phase,
  output logic              stop,
  output logic              flag_we,
  output logic              nxt_z,
  output logic              nxt_c,
  output logic [REG_W-1:0]  nxt_p,
  output logic [REG_W-1:0]  nxt_q,
  output logic [REG_W-1:0]  nxt_n
);
  logic [REG_W-1:0]  elem, elem_diff, n_dec, step;
  logic [BYTE_W-1:0] byte_b, byte_diff;
  logic              n_last;

  assign elem      = rdata & size_mask(size);
  assign elem_diff = elem - q_reg;
  assign byte_b    = rdata[BYTE_W-1:0];
  assign byte_diff = hold - byte_b;
  assign n_dec     = n_reg - REG_W'(1);
  assign n_last    = (n_dec == '0);
  assign step      = size_bytes(size);

  always_comb begin
    adv_phase = 1'b0;
    stop      = 1'b0;
    flag_we   = 1'b0;
    nxt_z     = 1'b0;
    nxt_c     = 1'b0;
    nxt_p     = p_reg;
    nxt_q     = q_reg;
    nxt_n     = n_dec;
    case (op)
      OP_CMPU: begin
        if (!phase) begin
          adv_phase = 1'b1;
        end else begin
          nxt_p   = p_reg + REG_W'(1);
          nxt_q   = q_reg + REG_W'(1);
          flag_we = 1'b1;
          nxt_z   = (byte_diff == '0);
          nxt_c   = (hold >= byte_b);
          stop    = (hold != byte_b) || (hold == '0) || n_last;
        end
      end
      OP_MOVF, OP_MOVU, OP_MOVB: begin
        if (!phase) begin
          adv_phase = 1'b1;
        end else begin
          nxt_p = (op == OP_MOVB) ? p_reg - REG_W'(1) : p_reg + REG_W'(1);
          nxt_q = (op == OP_MOVB) ? q_reg - REG_W'(1) : q_reg + REG_W'(1);
          stop  = n_last || ((op == OP_MOVU) && (hold == '0));
        end
      end
      OP_FILL: begin
        nxt_p = p_reg + step;
        stop  = n_last;
      end
      OP_UNTIL: begin
        nxt_p   = p_reg + step;
        flag_we = 1'b1;
        nxt_z   = (elem_diff == '0);
        nxt_c   = (elem <= q_reg);
        stop    = (elem == q_reg) || n_last;
      end
      OP_WHILE: begin
        nxt_p   = p_reg + step;
        flag_we = 1'b1;
        nxt_z   = n_last;
        nxt_c   = (elem <= q_reg);
        stop    = (elem != q_reg) || n_last;
      end
      default: stop = 1'b1;
    endcase
  end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_in,
  input  logic [SZ_W-1:0]   size_in,
  input  logic [REG_W-1:0]  p_in,
  input  logic [REG_W-1:0]  q_in,
  input  logic [REG_W-1:0]  n_in,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [REG_W-1:0]  p_out,
  output logic [REG_W-1:0]  q_out,
  output logic [REG_W-1:0]  n_out,
  output logic              flag_z,
  output logic              flag_c,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [REG_W-1:0]  mem_req_addr,
  output logic [SZ_W-1:0]   mem_req_size,
  output logic [REG_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [REG_W-1:0]  mem_rsp_rdata
);
  strop_state_e      state_q;
  strop_op_e         op_q, op_start;
  logic              phase_q, z_q, c_q, err_q, start_bad, step_ev;
  logic [SZ_W-1:0]   size_q;
  logic [REG_W-1:0]  p_q, q_q, n_q;
  logic [BYTE_W-1:0] hold_q;

  logic              adv_phase, stop, flag_we, nxt_z, nxt_c;
  logic [REG_W-1:0]  nxt_p, nxt_q, nxt_n;

  assign op_start  = strop_op_e'(op_in);
  assign start_bad = (op_start == OP_RSVD) || (op_sized(op_start) && (size_in == 2'd3));

  strop_req_gen u_req (
    .op(op_q), .phase(phase_q), .size(size_q), .p_reg(p_q), .q_reg(q_q),
    .hold(hold_q), .req_write(mem_req_write), .req_addr(mem_req_addr),
    .req_size(mem_req_size), .req_wdata(mem_req_wdata)
  );

  strop_step_eval u_eval (
    .op(op_q), .phase(phase_q), .size(size_q), .p_reg(p_q), .q_reg(q_q),
    .n_reg(n_q), .hold(hold_q), .rdata(mem_rsp_rdata),
    .adv_phase(adv_phase), .stop(stop), .flag_we(flag_we),
    .nxt_z(nxt_z), .nxt_c(nxt_c), .nxt_p(nxt_p), .nxt_q(nxt_q), .nxt_n(nxt_n)
  );

  assign step_ev = ((state_q == ST_REQ) && mem_req_ready && mem_req_write) ||
                   ((state_q == ST_WAIT) && mem_rsp_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_CMPU;
      size_q  <= '0;
      phase_q <= 1'b0;
      p_q     <= '0;
      q_q     <= '0;
      n_q     <= '0;
      hold_q  <= '0;
      z_q     <= 1'b0;
      c_q     <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_start;
            size_q  <= size_in;
            p_q     <= p_in;
            q_q     <= q_in;
            n_q     <= n_in;
            phase_q <= 1'b0;
            err_q   <= start_bad;
            if (start_bad || (n_in == '0)) state_q <= ST_DONE;
            else                           state_q <= ST_REQ;
          end
        end
        ST_REQ:  if (mem_req_ready && !mem_req_write) state_q <= ST_WAIT;
        ST_WAIT: ;
        default: state_q <= ST_IDLE;
      endcase
      if (step_ev) begin
        if (adv_phase) begin
          hold_q  <= mem_rsp_rdata[BYTE_W-1:0];
          phase_q <= 1'b1;
          state_q <= ST_REQ;
        end else begin
          p_q     <= nxt_p;
          q_q     <= nxt_q;
          n_q     <= nxt_n;
          phase_q <= 1'b0;
          if (flag_we) begin
            z_q <= nxt_z;
            c_q <= nxt_c;
          end
          state_q <= stop ? ST_DONE : ST_REQ;
        end
      end
    end
  end

  assign busy          = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign done          = (state_q == ST_DONE);
  assign err           = done && err_q;
  assign mem_req_valid = (state_q == ST_REQ);
  assign p_out         = p_q;
  assign q_out         = q_q;
  assign n_out         = n_q;
  assign flag_z        = z_q;
  assign flag_c        = c_q;
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk
  import strop_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op_in,
  input logic [SZ_W-1:0]  size_in,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             flag_z,
  input logic             flag_c,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [REG_W-1:0] mem_req_addr,
  input logic [REG_W-1:0] mem_req_wdata
);
  logic bad_start;
  assign bad_start = start && !busy && !done &&
                     ((op_in == 3'd7) || ((op_in >= 3'd4) && (size_in == 2'd3)));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_wdata) && $stable(mem_req_write)));

  a_r11_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r12_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r10_illegal_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    bad_start |=> (done && err && !mem_req_valid));

  a_r1_flags_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(flag_z) && $stable(flag_c)));
endmodule

bind strop_engine strop_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .size_in(size_in),
  .busy(busy), .done(done), .err(err), .flag_z(flag_z), .flag_c(flag_c),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/strop_engine_tb_top.sv
module strop_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [2:0]  op_in = '0;
  logic [1:0]  size_in = '0;
  logic [31:0] p_in = '0, q_in = '0, n_in = '0;
  logic        busy, done, err, flag_z, flag_c;
  logic [31:0] p_out, q_out, n_out;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;

  strop_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .size_in(size_in),
    .p_in(p_in), .q_in(q_in), .n_in(n_in), .busy(busy), .done(done), .err(err),
    .p_out(p_out), .q_out(q_out), .n_out(n_out), .flag_z(flag_z), .flag_c(flag_c),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model: 256 bytes, reset pattern 0x80|addr, stalling ready
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic       tb_we = 1'b0;
  logic [7:0] tb_wa = '0, tb_wd = '0;
  logic [3:0] tick;
  int         acc_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h80 | 8'(i);
      tick          <= '0;
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      acc_cnt       <= 0;
    end else begin
      tick          <= tick + 4'd1;
      mem_req_ready <= (tick[1:0] != 2'd1);
      mem_rsp_valid <= 1'b0;
      if (tb_we) mem[tb_wa] <= tb_wd;
      if (mem_req_valid && mem_req_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (mem_req_write) begin
          for (int k = 0; k < (1 << mem_req_size); k++)
            mem[8'(mem_req_addr + 32'(k))] <= mem_req_wdata[8*k +: 8];
        end else begin
          mem_rsp_valid <= 1'b1;
          for (int k = 0; k < 4; k++)
            mem_rsp_rdata[8*k +: 8] <= mem[8'(mem_req_addr + 32'(k))];
        end
      end
    end
  end

  typedef struct {
    logic [31:0] p, q, n;
    logic        z, c, e;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0, done_cnt = 0, issue_cnt = 0;
  logic ref_z = 1'b0, ref_c = 1'b0;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt <= done_cnt + 1;
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "done with no operation pending");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({p_out, q_out, n_out, flag_z, flag_c, err} == {e.p, e.q, e.n, e.z, e.c, e.e}, e.tag,
          $sformatf("got p=%h q=%h n=%h z=%b c=%b e=%b exp p=%h q=%h n=%h z=%b c=%b e=%b",
                    p_out, q_out, n_out, flag_z, flag_c, err, e.p, e.q, e.n, e.z, e.c, e.e));
      end
    end
  end

  // requirement-level model of every operation against ref_mem
  task automatic model(input logic [2:0] op, input logic [1:0] sz,
                       input logic [31:0] a1, a2, a3, input string tag,
                       output exp_t e, output int acc);
    logic [31:0] p = a1, q = a2, n = a3, el = '0;
    logic [7:0]  x = '0, y = '0;
    int          step = 1 << sz;
    bit          fin = 1'b0;
    acc = 0;
    e.e = 1'b0;
    if (op == 3'd7 || (op >= 3'd4 && sz == 2'd3)) begin
      e.e = 1'b1;
    end else if (op == 3'd0) begin
      if (n != 0) begin
        while (!fin) begin
          x = ref_mem[p[7:0]]; y = ref_mem[q[7:0]]; acc += 2;
          p++; q++; n--;
          fin = (x != y) || (x == 0) || (n == 0);
        end
        ref_z = (8'(x - y) == 0); ref_c = (x >= y);
      end
    end else if (op <= 3'd3) begin
      while (n != 0 && !fin) begin
        x = ref_mem[q[7:0]]; ref_mem[p[7:0]] = x; acc += 2;
        if (op == 3'd2) begin p--; q--; end else begin p++; q++; end
        n--;
        fin = (op == 3'd3) && (x == 0);
      end
    end else if (op == 3'd4) begin
      while (n != 0) begin
        for (int k = 0; k < step; k++) ref_mem[8'(p + 32'(k))] = q[8*k +: 8];
        acc++; p += 32'(step); n--;
      end
    end else if (n != 0) begin
      while (!fin) begin
        el = '0;
        for (int k = 0; k < step; k++) el[8*k +: 8] = ref_mem[8'(p + 32'(k))];
        acc++; p += 32'(step); n--;
        fin = ((op == 3'd5) ? (el == q) : (el != q)) || (n == 0);
      end
      ref_z = (op == 3'd5) ? (el == q) : (n == 0);
      ref_c = (el <= q);
    end
    e.p = p; e.q = q; e.n = n; e.z = ref_z; e.c = ref_c; e.tag = tag;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
    ref_mem[a] = d;
  endtask

  // driver: pushes expected item, starts op, waits, checks memory and access count
  task automatic run_op(input logic [2:0] op, input logic [1:0] sz,
                        input logic [31:0] a1, a2, a3, input string tag,
                        input bit poke_busy = 1'b0);
    exp_t e;
    int   acc_exp, acc0;
    bit   same = 1'b1;
    model(op, sz, a1, a2, a3, tag, e, acc_exp);
    exp_q.push_back(e);
    @(negedge clk);
    acc0 = acc_cnt;
    op_in = op; size_in = sz; p_in = a1; q_in = a2; n_in = a3; start = 1'b1;
    issue_cnt++;
    @(negedge clk); start = 1'b0;
    if (poke_busy) begin
      @(negedge clk);
      check(busy, tag, "engine not busy during long copy");
      op_in = 3'd4; size_in = 2'd2; p_in = 32'h0; q_in = 32'hDEAD_BEEF; n_in = 32'd8;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt < issue_cnt) @(negedge clk);
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) same = 1'b0;
    check(same, tag, "memory contents differ from expected image");
    check(acc_cnt - acc0 == acc_exp, tag,
          $sformatf("accesses got %0d exp %0d", acc_cnt - acc0, acc_exp));
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h80 | 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!busy && !done && !mem_req_valid && !flag_z && !flag_c, "R12",
          $sformatf("reset busy=%b done=%b valid=%b z=%b c=%b exp all 0",
                    busy, done, mem_req_valid, flag_z, flag_c));

    poke(8'h10, "a"); poke(8'h11, "b"); poke(8'h12, "c"); poke(8'h13, 8'h00);
    poke(8'h20, "a"); poke(8'h21, "b"); poke(8'h22, "c"); poke(8'h23, 8'h00);
    poke(8'h30, "a"); poke(8'h31, "b"); poke(8'h32, "d");
    poke(8'h38, "a"); poke(8'h39, "b"); poke(8'h3A, "z");
    run_op(3'd0, 2'd0, 32'h10, 32'h20, 32'd10, "R2 compare stops at zero byte");
    run_op(3'd0, 2'd0, 32'h30, 32'h38, 32'd8,  "R3 compare mismatch below");
    run_op(3'd0, 2'd0, 32'h38, 32'h30, 32'd8,  "R3 compare mismatch above");
    run_op(3'd0, 2'd0, 32'h10, 32'h20, 32'd2,  "R2 compare count exhausted");
    run_op(3'd0, 2'd0, 32'h30, 32'h38, 32'd0,  "R1 compare zero count");

    run_op(3'd1, 2'd0, 32'h40, 32'h60, 32'd5,  "R4 forward copy");
    run_op(3'd2, 2'd0, 32'h47, 32'h6F, 32'd4,  "R4 backward copy");
    run_op(3'd1, 2'd0, 32'h40, 32'h60, 32'd0,  "R4 copy zero count");
    run_op(3'd1, 2'd3, 32'h48, 32'h68, 32'd2,  "R9 copy ignores size code");
    poke(8'h50, "h"); poke(8'h51, "i"); poke(8'h52, 8'h00);
    run_op(3'd3, 2'd0, 32'h70, 32'h50, 32'd9,  "R5 copy until zero");
    run_op(3'd1, 2'd0, 32'h78, 32'h40, 32'd12, "R12 start ignored while busy", 1'b1);

    run_op(3'd4, 2'd0, 32'h80, 32'h0000_00A5, 32'd3, "R6 fill bytes");
    run_op(3'd4, 2'd1, 32'h90, 32'h1234_BEEF, 32'd2, "R6 fill halfwords");
    run_op(3'd4, 2'd2, 32'hA0, 32'hCAFE_F00D, 32'd2, "R6 fill words");

    poke(8'hB0, 8'h01); poke(8'hB1, 8'h02); poke(8'hB2, 8'h03); poke(8'hB3, 8'h44);
    run_op(3'd5, 2'd0, 32'hB0, 32'h44, 32'd10, "R7 search until byte found");
    run_op(3'd5, 2'd1, 32'hC0, 32'h1, 32'd3,   "R7 search until not found");
    poke(8'hD0, 8'h34); poke(8'hD1, 8'h12); poke(8'hD2, 8'h99); poke(8'hD3, 8'h77);
    run_op(3'd5, 2'd1, 32'hD0, 32'h1234, 32'd4,     "R9 halfword zero extension");
    run_op(3'd5, 2'd2, 32'hD0, 32'h7799_1234, 32'd2, "R9 word element");
    run_op(3'd5, 2'd0, 32'hD0, 32'h5, 32'd0,        "R1 search zero count");

    poke(8'hE0, 8'h07); poke(8'hE1, 8'h07); poke(8'hE2, 8'h07); poke(8'hE3, 8'h09);
    run_op(3'd6, 2'd0, 32'hE0, 32'h7, 32'd8, "R8 search while stops on differ");
    run_op(3'd6, 2'd0, 32'hE0, 32'h7, 32'd3, "R8 search while count exhausted");
    run_op(3'd6, 2'd0, 32'hE0, 32'h7, 32'd0, "R1 search while zero count");

    run_op(3'd4, 2'd3, 32'h80, 32'h11, 32'd3, "R10 fill illegal size");
    run_op(3'd6, 2'd3, 32'hE0, 32'h7, 32'd3,  "R10 search illegal size");
    run_op(3'd7, 2'd0, 32'h10, 32'h20, 32'd3, "R10 reserved op");

    @(negedge clk);
    check(!busy && !done, "R12", $sformatf("idle after run busy=%b done=%b exp 0 0", busy, done));
    report();
  end
endmodule